// File: doc/BRIEF.md
# Camera Parallel Video Output Formatter

This block sits at the output of a camera's processing chain. It takes processed pixel bytes with frame-level and line-level qualifiers and drives a parallel video port. The port carries an 8-bit data bus, two framing strobes and a pixel clock. Every input byte is delayed by a fixed four-slot pipeline. In the embedded-timing modes, that delay lets a four-byte start-of-line marker be placed in front of the first pixel of a line without stalling the stream.

A two-bit configuration input picks the signalling style. Bit 1 selects strobe framing (0) or ITU-R BT.656 embedded markers (1). Bit 0 selects a pixel clock that pulses only on useful slots (0) or on every slot (1). The configuration is applied only while no frame is in flight, so a frame never mixes two styles. An active-low output-enable pin and a configuration bit for high impedance can each release the port.

Input rules: lines occur only while the frame qualifier is high. Each line rise comes at least 8 cycles after the frame rise or the previous line fall. The frame falls at least 8 cycles after the last line falls. In embedded modes pixel bytes are never 0x00 or 0xFF.

Top module: `cam_video_out`

## Requirements
- R1: In strobe modes, `vidFrame`, `vidLine` and `vidData` after clock edge e reflect `inFrame`, `inLine` and `inData` as sampled at edge e-4. `vidData` is 0x00 whenever that delayed line qualifier is low.
- R2: With gated clocking (`cfgMode[0]`=0), `pixClk` pulses high in the low phase of `clk` only for slots that carry a line pixel or, in embedded modes, a marker byte. The number of pulses equals the number of such slots.
- R3: With uniform clocking (`cfgMode[0]`=1), `pixClk` pulses once in every slot, including blanking.
- R4: In embedded modes (`cfgMode[1]`=1), the four slots right before a line's first pixel carry 0xFF, 0x00, 0x00, 0x80. The first of these is the slot loaded at the edge where `inLine` is first seen high.
- R5: In embedded modes, the four slots right after a line's last pixel carry 0xFF, 0x00, 0x00, 0x9D. The fourth byte has bit 7 = 1, bit 6 = field (0), bit 5 = vertical blank (0 inside a frame) and bit 4 = H (1 for end of line, 0 for start of line). Bits 3..0 are V^H, F^H, F^V and F^V^H.
- R6: In embedded modes, `vidFrame` and `vidLine` stay low. Slots with neither a pixel nor a marker carry 0x80 and 0x10, changing value on every consecutive slot.
- R7: A new `cfgMode` value takes effect only after an edge at which `inFrame` is low, no delayed frame slot remains in the pipeline and no marker is in progress. It governs the slot loaded at the next edge.
- R8: `padDriveEn` is 0, and `vidData`, `vidFrame`, `vidLine` and `pixClk` are high impedance, whenever `outEnN` is 1 or `cfgHiZ` is 1. Otherwise `padDriveEn` is 1.
- R9: During reset (`rstN`=0), `vidData` is 0x00, `vidFrame` and `vidLine` are low and `pixClk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one pixel slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Bit 1: embedded markers; bit 0: uniform pixel clock |
| cfgHiZ | input | 1 | Configuration request to release the port |
| outEnN | input | 1 | Active-low output enable pin |
| inFrame | input | 1 | Input frame qualifier |
| inLine | input | 1 | Input line qualifier; pixel valid when high |
| inData | input | 8 | Input pixel byte |
| vidData | output | 8 | Output data bus |
| vidFrame | output | 1 | Output frame strobe |
| vidLine | output | 1 | Output line strobe |
| pixClk | output | 1 | Output pixel clock; rises mid-slot |
| padDriveEn | output | 1 | High while the port is driven |

## Verification
Each output slot is loaded at a clock edge and shows input from four edges earlier. The start marker, however, begins in the very slot whose edge first sees the line rise, and the end marker begins in the slot right after the delayed last pixel. The bench drives inputs three nanoseconds after an edge and reads every output one nanosecond after the following falling clock edge. At that point `pixClk` shows the slot's gate level and the data bus shows the byte loaded at that edge. It also counts `pixClk` rising edges over each frame window. Its reference model moves the mode over only at edges that satisfy the idle rule, so the slot right after a configuration change is predicted under the old mode.

// File: rtl/cam_fmt_pkg.sv
package cam_fmt_pkg;

  localparam int MarkLen = 4;
  localparam logic [7:0] BlankEven = 8'h80;
  localparam logic [7:0] BlankOdd  = 8'h10;

  typedef struct packed {
    logic       embed;
    logic       uniform;
    logic       mkEmit;
    logic [1:0] mkIdx;
    logic       mkEav;
    logic       blankAlt;
  } fmtCtrlT;

  function automatic logic [7:0] markerByte(input logic [1:0] idx, input logic f,
                                            input logic v, input logic h);
    case (idx)
      2'd0:    markerByte = 8'hFF;
      2'd1,
      2'd2:    markerByte = 8'h00;
      default: markerByte = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endcase
  endfunction

endpackage

// File: rtl/cam_fmt_ctrl.sv
module cam_fmt_ctrl
  import cam_fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic       inFrame,
  input  logic       inLine,
  input  logic       pipeFrameAny,
  input  logic       dlyLine,
  input  logic       outLine,
  output fmtCtrlT    ctl
);

  logic [1:0] modeQ;
  logic       linePrevQ;
  logic       mkBusyQ;
  logic [1:0] mkCntQ;
  logic       mkEavQ;
  logic       phaseQ;
  logic       startSav;
  logic       startEav;
  logic       frameIdle;

  // Line starts are seen at the input; line ends at the pipeline tail.
  assign startSav  = modeQ[1] && inLine && !linePrevQ && !mkBusyQ;
  assign startEav  = modeQ[1] && outLine && !dlyLine && !mkBusyQ;
  assign frameIdle = !inFrame && !pipeFrameAny && !mkBusyQ;

  always_comb begin
    ctl.embed    = modeQ[1];
    ctl.uniform  = modeQ[0];
    ctl.mkEmit   = mkBusyQ || startSav || startEav;
    ctl.mkIdx    = mkBusyQ ? mkCntQ : 2'd0;
    ctl.mkEav    = mkBusyQ ? mkEavQ : startEav;
    ctl.blankAlt = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= 2'd0;
      linePrevQ <= 1'b0;
      mkBusyQ   <= 1'b0;
      mkCntQ    <= 2'd0;
      mkEavQ    <= 1'b0;
      phaseQ    <= 1'b0;
    end else begin
      linePrevQ <= inLine;
      phaseQ    <= !phaseQ;
      if (frameIdle) modeQ <= cfgMode;
      if (mkBusyQ) begin
        mkCntQ <= 2'(mkCntQ + 2'd1);
        if (mkCntQ == 2'(MarkLen - 1)) mkBusyQ <= 1'b0;
      end else if (startSav || startEav) begin
        mkBusyQ <= 1'b1;
        mkCntQ  <= 2'd1;
        mkEavQ  <= startEav;
      end
    end
  end

endmodule

// File: rtl/cam_fmt_dp.sv
module cam_fmt_dp
  import cam_fmt_pkg::*;
#(
  parameter int DataW = 8,
  parameter int Depth = MarkLen
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inFrame,
  input  logic             inLine,
  input  logic [DataW-1:0] inData,
  input  fmtCtrlT          ctl,
  output logic             pipeFrameAny,
  output logic             dlyLine,
  output logic             outLine,
  output logic [DataW-1:0] dataQ,
  output logic             fvQ,
  output logic             lvQ,
  output logic             gateQ
);

  localparam int CodeShift = DataW - 8;

  logic [Depth-1:0]            frameP;
  logic [Depth-1:0]            lineP;
  logic [Depth-1:0][DataW-1:0] dataP;
  logic                        dlyFrame;
  logic [DataW-1:0]            dlyData;
  logic [DataW-1:0]            mkCode;
  logic [DataW-1:0]            blankCode;

  assign dlyFrame     = frameP[Depth-1];
  assign dlyLine      = lineP[Depth-1];
  assign dlyData      = dataP[Depth-1];
  assign pipeFrameAny = |frameP;

  assign mkCode    = DataW'(markerByte(ctl.mkIdx, 1'b0, !dlyFrame, ctl.mkEav)) << CodeShift;
  assign blankCode = DataW'(ctl.blankAlt ? BlankOdd : BlankEven) << CodeShift;

  // Alignment delay: one stage per marker byte.
  genvar g;
  generate
    for (g = 0; g < Depth; g++) begin : gStage
      always_ff @(posedge clk) begin
        if (!rstN) begin
          frameP[g] <= 1'b0;
          lineP[g]  <= 1'b0;
          dataP[g]  <= '0;
        end else if (g == 0) begin
          frameP[g] <= inFrame;
          lineP[g]  <= inLine;
          dataP[g]  <= inData;
        end else begin
          frameP[g] <= frameP[(g == 0) ? 0 : g-1];
          lineP[g]  <= lineP[(g == 0) ? 0 : g-1];
          dataP[g]  <= dataP[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLine <= 1'b0;
      dataQ   <= '0;
      fvQ     <= 1'b0;
      lvQ     <= 1'b0;
      gateQ   <= 1'b0;
    end else begin
      outLine <= dlyLine;
      if (ctl.embed) begin
        fvQ   <= 1'b0;
        lvQ   <= 1'b0;
        dataQ <= ctl.mkEmit ? mkCode : (dlyLine ? dlyData : blankCode);
        gateQ <= ctl.uniform || ctl.mkEmit || dlyLine;
      end else begin
        fvQ   <= dlyFrame;
        lvQ   <= dlyLine;
        dataQ <= dlyLine ? dlyData : '0;
        gateQ <= ctl.uniform || dlyLine;
      end
    end
  end

endmodule

// File: rtl/cam_video_out.sv
module cam_video_out
  import cam_fmt_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             cfgHiZ,
  input  logic             outEnN,
  input  logic             inFrame,
  input  logic             inLine,
  input  logic [DataW-1:0] inData,
  output logic [DataW-1:0] vidData,
  output logic             vidFrame,
  output logic             vidLine,
  output logic             pixClk,
  output logic             padDriveEn
);

  fmtCtrlT          ctl;
  logic             pipeFrameAny;
  logic             dlyLine;
  logic             outLine;
  logic [DataW-1:0] dataQ;
  logic             fvQ;
  logic             lvQ;
  logic             gateQ;

  cam_fmt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgMode      (cfgMode),
    .inFrame      (inFrame),
    .inLine       (inLine),
    .pipeFrameAny (pipeFrameAny),
    .dlyLine      (dlyLine),
    .outLine      (outLine),
    .ctl          (ctl)
  );

  cam_fmt_dp #(.DataW(DataW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inFrame      (inFrame),
    .inLine       (inLine),
    .inData       (inData),
    .ctl          (ctl),
    .pipeFrameAny (pipeFrameAny),
    .dlyLine      (dlyLine),
    .outLine      (outLine),
    .dataQ        (dataQ),
    .fvQ          (fvQ),
    .lvQ          (lvQ),
    .gateQ        (gateQ)
  );

  // Pixel clock rises mid-slot; the gate changes only while clk is high.
  assign padDriveEn = !outEnN && !cfgHiZ;
  assign vidData    = padDriveEn ? dataQ : 'z;
  assign vidFrame   = padDriveEn ? fvQ : 1'bz;
  assign vidLine    = padDriveEn ? lvQ : 1'bz;
  assign pixClk     = padDriveEn ? (!clk && gateQ) : 1'bz;

endmodule

// File: rtl/cam_video_out_chk.sv
module cam_video_out_chk #(
  parameter int DataW = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             embed,
  input logic             uniform,
  input logic [DataW-1:0] data,
  input logic             fv,
  input logic             lv,
  input logic             gate
);

  logic [7:0] xy;
  assign xy = data[DataW-1 -: 8];

  // R2: gated strobe mode clocks exactly the line slots
  a_r2_gated_follows_line: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!embed && !uniform)) |-> (gate == lv));

  // R3: uniform clocking never drops a slot
  a_r3_uniform_every_slot: assert property (@(posedge clk) disable iff (!rstN)
    $past(uniform) |-> gate);

  // R6: strobes silent in embedded modes
  a_r6_embed_strobes_low: assert property (@(posedge clk) disable iff (!rstN)
    $past(embed) |-> (!fv && !lv));

  // R5: a marker lead byte is followed by two zero bytes
  a_r5_marker_zeros: assert property (@(posedge clk) disable iff (!rstN)
    ($past(embed) && gate && (xy == 8'hFF)) |=> (xy == 8'h00) ##1 (xy == 8'h00));

  // R4: the fourth marker byte carries consistent protection bits
  a_r4_xy_protect: assert property (@(posedge clk) disable iff (!rstN)
    ($past(embed) && ($past(xy, 3) == 8'hFF) && ($past(xy, 2) == 8'h00) && ($past(xy, 1) == 8'h00))
    |-> (xy[7] && (xy[3] == (xy[5] ^ xy[4])) && (xy[2] == (xy[6] ^ xy[4]))
         && (xy[1] == (xy[6] ^ xy[5])) && (xy[0] == (xy[6] ^ xy[5] ^ xy[4]))));

endmodule

bind cam_video_out cam_video_out_chk #(.DataW(DataW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .embed   (ctl.embed),
  .uniform (ctl.uniform),
  .data    (dataQ),
  .fv      (fvQ),
  .lv      (lvQ),
  .gate    (gateQ)
);

// File: tb/tb_cam_video_out.sv
module tb_cam_video_out;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] swMode;
    logic       sw;
    logic [3:0] lines;
    logic [5:0] width;
    logic [4:0] gap;
  } scnT;

  localparam int NumScn = 8;
  localparam scnT Scn [NumScn] = '{
    '{2'd0, 2'd0, 1'b0, 4'd2, 6'd5, 5'd8},
    '{2'd1, 2'd0, 1'b0, 4'd2, 6'd4, 5'd9},
    '{2'd2, 2'd0, 1'b0, 4'd2, 6'd3, 5'd8},
    '{2'd3, 2'd0, 1'b0, 4'd3, 6'd2, 5'd10},
    '{2'd2, 2'd0, 1'b0, 4'd1, 6'd1, 5'd8},
    '{2'd0, 2'd0, 1'b0, 4'd1, 6'd1, 5'd8},
    '{2'd0, 2'd2, 1'b1, 4'd2, 6'd3, 5'd8},
    '{2'd2, 2'd1, 1'b1, 4'd2, 6'd3, 5'd9}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cfgMode;
  logic       cfgHiZ;
  logic       outEnN;
  logic       inFrame;
  logic       inLine;
  logic [7:0] inData;
  wire  [7:0] vidData;
  wire        vidFrame;
  wire        vidLine;
  wire        pixClk;
  wire        padDriveEn;

  always #2 clk = ~clk;

  cam_video_out dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgHiZ(cfgHiZ), .outEnN(outEnN),
    .inFrame(inFrame), .inLine(inLine), .inData(inData),
    .vidData(vidData), .vidFrame(vidFrame), .vidLine(vidLine),
    .pixClk(pixClk), .padDriveEn(padDriveEn)
  );

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // pixel clock pulse counter
  bit countOn = 1'b0;
  int edgeCnt = 0;
  always @(posedge pixClk) if (countOn) edgeCnt++;

  // stimulus arrays and reference model state
  logic       fA [128];
  logic       lA [128];
  logic [7:0] dA [128];
  logic [1:0] cA [128];
  int         nSlots;
  logic [1:0] curMode = 2'd0;
  int         mkPos = -1;
  bit         mkEavM = 1'b0;
  int         gSlot = 0;
  int         lastBlankSlot = -10;
  logic [7:0] lastBlankVal = 8'h00;

  function automatic logic atL(input int i);
    return (i < 0) ? 1'b0 : lA[i];
  endfunction
  function automatic logic atF(input int i);
    return (i < 0) ? 1'b0 : fA[i];
  endfunction
  function automatic logic [7:0] atD(input int i);
    return (i < 0) ? 8'h00 : dA[i];
  endfunction

  task automatic buildScn(input int s);
    int k = 0;
    for (int i = 0; i < 6; i++) begin
      fA[k] = 0; lA[k] = 0; dA[k] = 0; cA[k] = Scn[s].mode; k++;
    end
    for (int ln = 0; ln < int'(Scn[s].lines); ln++) begin
      for (int i = 0; i < int'(Scn[s].gap); i++) begin
        fA[k] = 1; lA[k] = 0; dA[k] = 0; k++;
      end
      for (int i = 0; i < int'(Scn[s].width); i++) begin
        fA[k] = 1; lA[k] = 1; dA[k] = 8'h40 + 8'((k * 7 + s) & 8'h3F); k++;
      end
    end
    for (int i = 0; i < 12; i++) begin
      fA[k] = 1; lA[k] = 0; dA[k] = 0; k++;
    end
    for (int i = 0; i < 10; i++) begin
      fA[k] = 0; lA[k] = 0; dA[k] = 0; k++;
    end
    nSlots = k;
    for (int i = 6; i < nSlots; i++)
      cA[i] = (Scn[s].sw && (i >= 6 + int'(Scn[s].gap))) ? Scn[s].swMode : Scn[s].mode;
  endtask

  task automatic runScn(input int s, input string tag, input string clkTag);
    int   bad = 0;
    int   expEdges = 0;
    string firstMsg = "";
    logic eFv, eLv, eGate, embedM, uniM, isMk, blankSlot, busyBefore, idle;
    logic [7:0] eData;
    buildScn(s);
    edgeCnt = 0;
    countOn = 1'b1;
    for (int e = 0; e < nSlots; e++) begin
      inFrame = fA[e]; inLine = lA[e]; inData = dA[e]; cfgMode = cA[e];
      @(posedge clk);
      #3;
      embedM = curMode[1];
      uniM   = curMode[0];
      if (mkPos < 0 && embedM && lA[e] && !atL(e-1)) begin mkPos = 0; mkEavM = 0; end
      else if (mkPos < 0 && embedM && atL(e-5) && !atL(e-4)) begin mkPos = 0; mkEavM = 1; end
      isMk = (mkPos >= 0);
      busyBefore = (mkPos >= 1);
      blankSlot = 1'b0;
      if (embedM) begin
        eFv = 0; eLv = 0;
        if (isMk) eData = (mkPos == 0) ? 8'hFF : (mkPos == 3) ? (mkEavM ? 8'h9D : 8'h80) : 8'h00;
        else if (atL(e-4)) eData = atD(e-4);
        else begin blankSlot = 1'b1; eData = 8'h00; end
        eGate = uniM | isMk | atL(e-4);
      end else begin
        eFv = atF(e-4); eLv = atL(e-4);
        eData = eLv ? atD(e-4) : 8'h00;
        eGate = uniM | eLv;
      end
      if (eGate) expEdges++;
      if (blankSlot) begin
        if (!((vidData == 8'h80) || (vidData == 8'h10)) ||
            ((lastBlankSlot == gSlot - 1) && (vidData == lastBlankVal))) begin
          bad++;
          if (firstMsg == "") firstMsg = $sformatf("R6 blank slot %0d act %0h prev %0h", e, vidData, lastBlankVal);
        end
        lastBlankSlot = gSlot;
        lastBlankVal  = vidData;
      end else if (vidData !== eData) begin
        bad++;
        if (firstMsg == "") firstMsg = $sformatf("%s data slot %0d act %0h exp %0h", isMk ? (mkEavM ? "R5" : "R4") : "R1", e, vidData, eData);
      end
      if (vidFrame !== eFv || vidLine !== eLv) begin
        bad++;
        if (firstMsg == "") firstMsg = $sformatf("%s strobes slot %0d act %0b%0b exp %0b%0b", embedM ? "R6" : "R1", e, vidFrame, vidLine, eFv, eLv);
      end
      if (pixClk !== eGate) begin
        bad++;
        if (firstMsg == "") firstMsg = $sformatf("%s pixClk slot %0d act %0b exp %0b", uniM ? "R3" : "R2", e, pixClk, eGate);
      end
      // model bookkeeping for the next slot
      mkPos = (mkPos < 0 || mkPos == 3) ? -1 : mkPos + 1;
      idle = !fA[e] && !atF(e-1) && !atF(e-2) && !atF(e-3) && !atF(e-4) && !busyBefore;
      if (idle) curMode = cA[e];
      gSlot++;
    end
    countOn = 1'b0;
    check(bad == 0, tag, $sformatf("scenario %0d stream (%s)", s, firstMsg), bad, 0);
    check(edgeCnt == expEdges, clkTag, $sformatf("scenario %0d pixClk pulses", s), edgeCnt, expEdges);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; cfgMode = 0; cfgHiZ = 0; outEnN = 0;
    inFrame = 0; inLine = 0; inData = 0;
    repeat (3) @(posedge clk);
    #3;
    // R9: reset state
    check(vidData == 8'h00, "R9", "reset vidData", int'(vidData), 0);
    check(vidFrame == 1'b0 && vidLine == 1'b0, "R9", "reset strobes", int'({vidFrame, vidLine}), 0);
    check(pixClk == 1'b0, "R9", "reset pixClk", int'(pixClk), 0);
    check(padDriveEn == 1'b1, "R8", "driven after reset", int'(padDriveEn), 1);
    rstN = 1;

    runScn(0, "R1", "R2");
    runScn(1, "R1", "R3");
    runScn(2, "R4/R5/R6", "R2");
    runScn(3, "R4/R5/R6", "R3");
    runScn(4, "R4/R5", "R2");
    runScn(5, "R1", "R2");
    runScn(6, "R7", "R2");
    runScn(7, "R7", "R3");

    // R8: either release source stops driving
    outEnN = 1; #1;
    check(padDriveEn == 1'b0, "R8", "outEnN high releases port", int'(padDriveEn), 0);
    outEnN = 0; cfgHiZ = 1; #1;
    check(padDriveEn == 1'b0, "R8", "cfgHiZ releases port", int'(padDriveEn), 0);
    cfgHiZ = 0; #1;
    check(padDriveEn == 1'b1, "R8", "port driven again", int'(padDriveEn), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule